// File: doc/BRIEF.md
# Three-Stage Pipeline Exception Sequencer

This block is the control skeleton of a fetch, decode and execute pipeline for 32-bit, word-aligned instructions. It owns the fetch address and the address and valid bit of the instruction in each later stage. Faults are never acted on where they are found. A fetch-side memory fault is attached to the instruction as a tag at fetch. An undefined opcode is attached as a tag at decode. The tags travel with the instruction, and an exception is raised only when a tagged instruction is valid in execute. A data fault is reported by the memory side while the instruction sits in execute.

A taken branch in execute redirects fetch and discards the two younger instructions together with their tags. A taken exception reports its kind and redirects fetch to the fixed vector of that kind. It also reports a link value equal to the current fetch address, which is the faulting address plus 8. Return code has to subtract that fixed offset. The block keeps a current status word and a saved copy. An exception saves the current word. A return that carries the restore flag copies the saved word back.

Top module: `pipe_exc_seq`

## Requirements
- R1: While `rst_n` is low, `exc_kind_o` reports reset (code 1) and `redirect_o` is high with target 0, and this overrides a data fault. After release, `pc_o` is 0, both stage valid bits are clear, `cur_status_o` is 0x81 and `saved_status_o` is 0.
- R2: Without a redirect, `pc_o` advances by 4 each cycle. A valid decode instruction sits at `pc_o`-4 and a valid execute instruction sits at `pc_o`-8. `pc_o` is always word aligned.
- R3: `fetch_fault_i` tags the instruction fetched in that cycle. When that instruction is valid in execute, the block takes the prefetch-fault exception (code 3), redirects to 0x0C, and drives `link_o` to the instruction address plus 8 with `link_we_o` high.
- R4: `dec_undef_i` tags the valid instruction in decode. When that instruction is valid in execute, the block takes the undefined exception (code 2) and redirects to 0x04.
- R5: A taken branch in execute (`exe_branch_i` while execute is valid and no exception is taken) discards the decode and fetch instructions. Their tags never raise an exception.
- R6: `exe_dfault_i` is sampled only while execute is valid. It raises the data-fault exception (code 4) with redirect to 0x10, and it wins over a prefetch or undefined tag on the same instruction. While execute is invalid it has no effect.
- R7: After any redirect, `exe_valid_o` is low for the next two cycles.
- R8: A taken branch with `exe_link_i` drives `link_o` to the branch address plus 4 with `link_we_o` high. The redirect target is `exe_target_i` with bits 1:0 forced to zero.
- R9: A taken exception copies `cur_status_o` into `saved_status_o`. It sets `cur_status_o` to 0x80 OR the exception code.
- R10: A taken branch with `exe_restore_i` copies `saved_status_o` into `cur_status_o`.
- R11: `exe_stat_we_i` with a valid execute instruction and no exception loads `exe_stat_i` into `cur_status_o` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_fault_i | input | 1 | Memory fault on the current fetch |
| dec_undef_i | input | 1 | Decoder flags the decode instruction as undefined |
| exe_dfault_i | input | 1 | Data fault for the execute instruction |
| exe_branch_i | input | 1 | Execute instruction is a taken branch or return |
| exe_target_i | input | 32 | Branch target address |
| exe_link_i | input | 1 | Branch writes a return link |
| exe_restore_i | input | 1 | Branch restores the saved status word |
| exe_stat_we_i | input | 1 | Execute instruction writes the status word |
| exe_stat_i | input | 8 | Status value to write |
| pc_o | output | 32 | Fetch address |
| dec_pc_o | output | 32 | Address of the decode instruction |
| exe_pc_o | output | 32 | Address of the execute instruction |
| dec_valid_o | output | 1 | Decode stage holds a live instruction |
| exe_valid_o | output | 1 | Execute stage holds a live instruction |
| exc_take_o | output | 1 | An exception is taken this cycle |
| exc_kind_o | output | 3 | Exception code: 0 none, 1 reset, 2 undefined, 3 prefetch, 4 data |
| redirect_o | output | 1 | Fetch is redirected next cycle |
| redirect_pc_o | output | 32 | Redirect target |
| link_o | output | 32 | Link value |
| link_we_o | output | 1 | Link value is valid |
| cur_status_o | output | 8 | Current status word |
| saved_status_o | output | 8 | Saved status word |

## Verification
The hardest case to reach is a tag that has already been attached but is destroyed before its instruction reaches execute. The stimulus raises a fetch fault and an undefined flag on the two instructions behind a branch, in the cycles when those instructions are in fetch and decode. It then confirms that no exception appears during the two refill cycles or when the branch target arrives in execute. Priority is tested by stacking a fetch fault, an undefined flag and a data fault on the same instruction. Status restore is tested by writing a status value, taking an exception after it, then returning through a restoring branch once the pipeline has refilled.

// File: rtl/pes_pkg.sv
// Shared types and constants for the exception sequencer.
// Assumes 32-bit byte addresses and 4-byte instructions.
package pes_pkg;
    localparam int XLEN     = 32;
    localparam int INSN_B   = 4;

    typedef enum logic [2:0] {
        EXC_NONE  = 3'd0,
        EXC_RESET = 3'd1,
        EXC_UNDEF = 3'd2,
        EXC_PABT  = 3'd3,
        EXC_DABT  = 3'd4
    } exc_kind_e;

    // Fixed vector address for each exception kind.
    function automatic logic [XLEN-1:0] vec_of(exc_kind_e k);
        case (k)
            EXC_UNDEF: return XLEN'(32'h04);
            EXC_PABT:  return XLEN'(32'h0C);
            EXC_DABT:  return XLEN'(32'h10);
            default:   return XLEN'(32'h00);
        endcase
    endfunction
endpackage

// File: rtl/pes_fetch.sv
// Fetch address register. It holds the address being fetched and steps by
// one instruction per cycle unless redirected.
// Assumes the redirect target is already word aligned.
module pes_fetch
    import pes_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            redirect,
    input  logic [XLEN-1:0] target,
    output logic [XLEN-1:0] pc
);
    // Advance or reload the fetch address.
    always_ff @(posedge clk) begin
        if (!rst_n)        pc <= vec_of(EXC_RESET);
        else if (redirect) pc <= target;
        else               pc <= pc + XLEN'(INSN_B);
    end

    AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        pc[1:0] == 2'b00) else $error("pc misaligned"); // R2
endmodule

// File: rtl/pes_stages.sv
// Decode and execute stage registers. They carry the address, a valid bit
// and the latent fault tags. A redirect clears both stages and their tags.
// Assumes fetch is always active, so each non-redirect cycle delivers one
// instruction into decode.
module pes_stages
    import pes_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            redirect,
    input  logic [XLEN-1:0] target,
    input  logic [XLEN-1:0] pc,
    input  logic            fetch_fault,
    input  logic            dec_undef,
    output logic            dec_valid,
    output logic [XLEN-1:0] dec_pc,
    output logic            exe_valid,
    output logic [XLEN-1:0] exe_pc,
    output logic            exe_pabt,
    output logic            exe_undef
);
    logic dec_pabt;

    // Shift instructions and tags down the pipe, or flush on a redirect.
    always_ff @(posedge clk) begin
        if (!rst_n || redirect) begin
            dec_valid <= 1'b0;
            exe_valid <= 1'b0;
            dec_pabt  <= 1'b0;
            exe_pabt  <= 1'b0;
            exe_undef <= 1'b0;
            dec_pc    <= (rst_n ? target : vec_of(EXC_RESET)) - XLEN'(INSN_B);
            exe_pc    <= (rst_n ? target : vec_of(EXC_RESET)) - XLEN'(2*INSN_B);
        end else begin
            dec_valid <= 1'b1;
            dec_pc    <= pc;
            dec_pabt  <= fetch_fault;
            exe_valid <= dec_valid;
            exe_pc    <= dec_pc;
            exe_pabt  <= dec_valid & dec_pabt;
            exe_undef <= dec_valid & dec_undef;
        end
    end

    AST_REFILL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> !dec_valid && !exe_valid) else $error("no flush"); // R7
    AST_REFILL_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> ##2 !exe_valid) else $error("early refill"); // R7
endmodule

// File: rtl/pes_resolve.sv
// Execute-stage resolver. It picks the exception by priority, forms the
// redirect and the link, and holds the current and saved status words.
// Priority: reset, data fault, prefetch fault, undefined, then branch.
module pes_resolve
    import pes_pkg::*;
#(
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XLEN-1:0]   pc,
    input  logic              exe_valid,
    input  logic [XLEN-1:0]   exe_pc,
    input  logic              exe_pabt,
    input  logic              exe_undef,
    input  logic              dfault,
    input  logic              branch,
    input  logic [XLEN-1:0]   br_target,
    input  logic              br_link,
    input  logic              br_restore,
    input  logic              stat_we,
    input  logic [STAT_W-1:0] stat_data,
    output logic              take,
    output exc_kind_e         kind,
    output logic              redirect,
    output logic [XLEN-1:0]   target,
    output logic [XLEN-1:0]   link,
    output logic              link_we,
    output logic [STAT_W-1:0] cur_stat,
    output logic [STAT_W-1:0] saved_stat
);
    localparam logic [STAT_W-1:0] MASK_BIT = STAT_W'(1) << (STAT_W-1);

    logic              br_take;
    logic [STAT_W-1:0] exc_stat;

    // Select the winning exception by fixed priority.
    always_comb begin
        if (!rst_n)                   kind = EXC_RESET;
        else if (exe_valid && dfault) kind = EXC_DABT;
        else if (exe_valid && exe_pabt)  kind = EXC_PABT;
        else if (exe_valid && exe_undef) kind = EXC_UNDEF;
        else                          kind = EXC_NONE;
    end

    // Form redirect, target and link from the exception or branch.
    always_comb begin
        take     = (kind != EXC_NONE);
        br_take  = exe_valid && branch && !take;
        redirect = take || br_take;
        target   = take ? vec_of(kind) : {br_target[XLEN-1:2], 2'b00};
        link     = take ? pc : exe_pc + XLEN'(INSN_B);
        link_we  = (take && rst_n) || (br_take && br_link);
        exc_stat = MASK_BIT | STAT_W'(kind);
    end

    // Save, restore or write the status words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_stat   <= MASK_BIT | STAT_W'(EXC_RESET);
            saved_stat <= '0;
        end else if (take) begin
            saved_stat <= cur_stat;
            cur_stat   <= exc_stat;
        end else if (br_take && br_restore) begin
            cur_stat   <= saved_stat;
        end else if (exe_valid && stat_we) begin
            cur_stat   <= stat_data;
        end
    end

    AST_DFAULT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (exe_valid && dfault) |-> (kind == EXC_DABT) && redirect
        && (target == vec_of(EXC_DABT))) else $error("dfault prio"); // R6
    AST_STATUS_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> saved_stat == $past(cur_stat)) else $error("save"); // R9
    AST_STATUS_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        (br_take && br_restore) |=> cur_stat == $past(saved_stat))
        else $error("restore"); // R10
endmodule

// File: rtl/pipe_exc_seq.sv
// Top of the exception sequencer: fetch register, stage registers and
// execute resolver. Faults become tags and act only in execute.
module pipe_exc_seq
    import pes_pkg::*;
#(
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_fault_i,
    input  logic              dec_undef_i,
    input  logic              exe_dfault_i,
    input  logic              exe_branch_i,
    input  logic [XLEN-1:0]   exe_target_i,
    input  logic              exe_link_i,
    input  logic              exe_restore_i,
    input  logic              exe_stat_we_i,
    input  logic [STAT_W-1:0] exe_stat_i,
    output logic [XLEN-1:0]   pc_o,
    output logic [XLEN-1:0]   dec_pc_o,
    output logic [XLEN-1:0]   exe_pc_o,
    output logic              dec_valid_o,
    output logic              exe_valid_o,
    output logic              exc_take_o,
    output logic [2:0]        exc_kind_o,
    output logic              redirect_o,
    output logic [XLEN-1:0]   redirect_pc_o,
    output logic [XLEN-1:0]   link_o,
    output logic              link_we_o,
    output logic [STAT_W-1:0] cur_status_o,
    output logic [STAT_W-1:0] saved_status_o
);
    logic      exe_pabt, exe_undef;
    exc_kind_e kind;

    pes_fetch u_fetch (
        .clk(clk), .rst_n(rst_n), .redirect(redirect_o),
        .target(redirect_pc_o), .pc(pc_o)
    );

    pes_stages u_stages (
        .clk(clk), .rst_n(rst_n), .redirect(redirect_o),
        .target(redirect_pc_o), .pc(pc_o), .fetch_fault(fetch_fault_i),
        .dec_undef(dec_undef_i), .dec_valid(dec_valid_o), .dec_pc(dec_pc_o),
        .exe_valid(exe_valid_o), .exe_pc(exe_pc_o), .exe_pabt(exe_pabt),
        .exe_undef(exe_undef)
    );

    pes_resolve #(.STAT_W(STAT_W)) u_resolve (
        .clk(clk), .rst_n(rst_n), .pc(pc_o), .exe_valid(exe_valid_o),
        .exe_pc(exe_pc_o), .exe_pabt(exe_pabt), .exe_undef(exe_undef),
        .dfault(exe_dfault_i), .branch(exe_branch_i),
        .br_target(exe_target_i), .br_link(exe_link_i),
        .br_restore(exe_restore_i), .stat_we(exe_stat_we_i),
        .stat_data(exe_stat_i), .take(exc_take_o), .kind(kind),
        .redirect(redirect_o), .target(redirect_pc_o), .link(link_o),
        .link_we(link_we_o), .cur_stat(cur_status_o),
        .saved_stat(saved_status_o)
    );

    assign exc_kind_o = kind;

    AST_DEC_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid_o |-> dec_pc_o == pc_o - XLEN'(INSN_B)) else $error("dec"); // R2
    AST_EXE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        exe_valid_o |-> exe_pc_o == pc_o - XLEN'(2*INSN_B)) else $error("exe"); // R2
    AST_EXC_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take_o |-> link_we_o && link_o == exe_pc_o + XLEN'(2*INSN_B))
        else $error("link"); // R3
endmodule

// File: tb/tb_pipe_exc_seq.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_pipe_exc_seq;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        fetch_fault_i, dec_undef_i, exe_dfault_i, exe_branch_i;
    logic [31:0] exe_target_i;
    logic        exe_link_i, exe_restore_i, exe_stat_we_i;
    logic [7:0]  exe_stat_i;
    logic [31:0] pc_o, dec_pc_o, exe_pc_o, redirect_pc_o, link_o;
    logic        dec_valid_o, exe_valid_o, exc_take_o, redirect_o, link_we_o;
    logic [2:0]  exc_kind_o;
    logic [7:0]  cur_status_o, saved_status_o;
    int nchk = 0;
    int nfail = 0;

    always #4 clk = ~clk;

    pipe_exc_seq dut (.*);

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clr();
        fetch_fault_i = 0; dec_undef_i = 0; exe_dfault_i = 0;
        exe_branch_i = 0; exe_target_i = 0; exe_link_i = 0;
        exe_restore_i = 0; exe_stat_we_i = 0; exe_stat_i = 0;
    endtask

    // Advance to the next negedge with inputs cleared.
    task automatic tick();
        @(posedge clk); @(negedge clk); clr();
    endtask

    // Reset; returns at cycle 0 (pc = 0) after release.
    task automatic do_reset();
        @(negedge clk); clr(); rst_n = 0;
        tick(); tick();
        rst_n = 1;
    endtask

    task automatic t_reset();
        @(negedge clk); clr(); rst_n = 0;
        tick();
        exe_dfault_i = 1; #1;
        chk("R1 kind in reset", 32'(exc_kind_o), 1);
        chk("R1 redirect", 32'(redirect_o), 1);
        chk("R1 target", redirect_pc_o, 0);
        tick(); rst_n = 1; #1;
        chk("R1 pc", pc_o, 0);
        chk("R1 dec_valid", 32'(dec_valid_o), 0);
        chk("R1 exe_valid", 32'(exe_valid_o), 0);
        chk("R1 cur", 32'(cur_status_o), 32'h81);
        chk("R1 saved", 32'(saved_status_o), 0);
    endtask

    task automatic t_flow();
        do_reset();
        exe_dfault_i = 1; #1;
        chk("R6 dfault ignored when exe invalid", 32'(exc_take_o), 0);
        tick(); tick(); tick(); #1;
        chk("R2 pc", pc_o, 32'hC);
        chk("R2 dec_pc", dec_pc_o, 32'h8);
        chk("R2 exe_pc", exe_pc_o, 32'h4);
        chk("R2 exe_valid", 32'(exe_valid_o), 1);
    endtask

    task automatic t_pabt();
        do_reset();
        fetch_fault_i = 1;
        tick(); tick(); #1;
        chk("R3 take", 32'(exc_take_o), 1);
        chk("R3 kind", 32'(exc_kind_o), 3);
        chk("R3 target", redirect_pc_o, 32'hC);
        chk("R3 link", link_o, 32'h8);
        chk("R3 link_we", 32'(link_we_o), 1);
        tick(); #1;
        chk("R3 pc at vector", pc_o, 32'hC);
        chk("R9 cur", 32'(cur_status_o), 32'h83);
        chk("R9 saved", 32'(saved_status_o), 32'h81);
        chk("R7 exe invalid 1", 32'(exe_valid_o), 0);
        tick(); #1;
        chk("R7 exe invalid 2", 32'(exe_valid_o), 0);
        tick(); #1;
        chk("R7 exe refilled", exe_pc_o, 32'hC);
    endtask

    task automatic t_undef();
        do_reset();
        tick();
        dec_undef_i = 1;
        tick(); #1;
        chk("R4 kind", 32'(exc_kind_o), 2);
        chk("R4 target", redirect_pc_o, 32'h4);
        chk("R4 link", link_o, 32'h8);
    endtask

    task automatic t_prio();
        do_reset();
        fetch_fault_i = 1;
        tick(); dec_undef_i = 1;
        tick(); exe_dfault_i = 1; #1;
        chk("R6 kind", 32'(exc_kind_o), 4);
        chk("R6 target", redirect_pc_o, 32'h10);
        tick(); #1;
        chk("R6 cur after dfault", 32'(cur_status_o), 32'h84);
    endtask

    task automatic t_flush();
        do_reset();
        tick(); fetch_fault_i = 1;
        tick(); dec_undef_i = 1; exe_branch_i = 1; exe_target_i = 32'h103; #1;
        chk("R8 aligned target", redirect_pc_o, 32'h100);
        chk("R5 no take on branch", 32'(exc_take_o), 0);
        tick(); #1;
        chk("R5 no take c3", 32'(exc_take_o), 0);
        chk("R5 pc", pc_o, 32'h100);
        tick(); #1;
        chk("R5 no take c4", 32'(exc_take_o), 0);
        tick(); #1;
        chk("R5 exe target", exe_pc_o, 32'h100);
        chk("R5 no take c5", 32'(exc_take_o), 0);
    endtask

    task automatic t_bl();
        do_reset();
        tick(); tick(); tick(); tick();
        exe_branch_i = 1; exe_link_i = 1; exe_target_i = 32'h40; #1;
        chk("R8 link", link_o, 32'hC);
        chk("R8 link_we", 32'(link_we_o), 1);
        tick(); #1;
        chk("R8 pc", pc_o, 32'h40);
    endtask

    task automatic t_status();
        do_reset();
        tick(); tick();
        exe_stat_we_i = 1; exe_stat_i = 8'h15; dec_undef_i = 1;
        tick(); #1;
        chk("R11 cur", 32'(cur_status_o), 32'h15);
        chk("R4 take", 32'(exc_kind_o), 2);
        tick(); #1;
        chk("R9 saved", 32'(saved_status_o), 32'h15);
        chk("R9 cur", 32'(cur_status_o), 32'h82);
        tick(); tick();
        exe_branch_i = 1; exe_restore_i = 1; exe_target_i = 32'h8; #1;
        chk("R10 exe valid", 32'(exe_valid_o), 1);
        tick(); #1;
        chk("R10 cur restored", 32'(cur_status_o), 32'h15);
        chk("R10 pc", pc_o, 32'h8);
    endtask

    initial begin
        clr(); rst_n = 0;
        t_reset(); t_flow(); t_pabt(); t_undef();
        t_prio(); t_flush(); t_bl(); t_status();
        $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        nchk++; nfail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end
endmodule